// File: doc/BRIEF.md
# Dual Down-Counting Timer Peripheral

This block is a memory-mapped peripheral with two independent down-counting timer channels. It sits behind a simple word-addressed register bus: a write strobe, a read strobe, a 12-bit byte address and 32-bit write and read data. Each channel has a stored reload value and a current count. It can run free, run periodically or fire once, through a prescaler of 1, 16 or 256. When the count steps down to zero, the channel raises a raw interrupt flag. The flag is gated by a per-channel enable, and the gated lines of both channels are ORed onto a single interrupt output.

Software programs a channel by writing its reload value, either with an immediate restart of the count or quietly for the next reload. It then writes the control word to choose the mode, the counter width and the prescaler, and to start counting. It services an interrupt by writing any value to the channel's clear register. A read returns its data in the cycle after the read strobe is sampled, and the read data holds its value until the next read. A block of fixed identification bytes sits at the top of the 4 KiB window.

Top module: `dtimer_top`

## Requirements
- R1: Channel 0 decodes byte addresses 0x00-0x1F and channel 1 decodes 0x20-0x3F. The word index is address bits 4:2: 0 reload (immediate), 1 current count, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 reload (background). Read data is registered: it shows the addressed value one cycle after `bus_rd` is sampled, and holds while `bus_rd` is low. Reads of word index 7, of any address with bits 1:0 nonzero, of 0xF00 and 0xF04, and of any other undecoded address return zero. Writes to those addresses have no effect.
- R2: Word reads from 0xFE0 through 0xFFC return, in increasing address order, the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with upper bits zero.
- R3: After reset each control register reads 0x20 (interrupt enable set, counter stopped). The reload value, the count and the raw flag all read 0, and `irq` is low.
- R4: A write to word 0 stores the reload value and loads the count with it in the same cycle. Writes to word 1 are ignored.
- R5: A write to word 6 stores the reload value and leaves the count untouched. The new value is used at the next reload. Words 0 and 6 both read back the stored reload value.
- R6: Control bit 0 selects one-shot, bit 6 periodic, bit 7 enable. When enabled, each count tick decrements a nonzero count. A tick at a count of zero reloads: with the stored reload value in periodic mode, and with all ones of the counter width in free-running mode (bits 0 and 6 both clear). In one-shot mode (bit 0 set, which takes priority over bit 6) the count holds at zero until word 0 is written.
- R7: Control bit 1 selects a 32-bit counter. When it is clear, only bits 15:0 count and compare to zero, and the count reads with bits 31:16 zero.
- R8: Control bits 3:2 set the tick rate: 00 and 11 give a tick every clock, 01 every 16 clocks, 10 every 256 clocks. The divider is cleared by every control write, so after a control write at edge E the first divided tick lands at edge E+16 (or E+256).
- R9: A tick that steps the count from 1 to 0 sets the raw flag (word 4, bit 0). A write of any value to word 3 clears it; if both happen in one cycle, the flag is set.
- R10: The masked status (word 5, bit 0) equals the raw flag ANDed with control bit 5. `irq` is the OR of both channels' masked status.
- R11: The control register stores bits 7:0 of the written value and reads them back, with bits 31:8 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one register write per sampled cycle |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` the next cycle |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt: OR of both channels' masked flags |

## Verification
The count is read back on every consecutive clock after a control write, and each sample is compared against an arithmetic model of the ticks elapsed. This is done in periodic, free-running 16-bit, free-running 32-bit and one-shot modes, which separates the three reload choices and the width masking. Sweeps at dividers 1, 16 and 256, and with the 11 encoding, show whether the divider was cleared by the control write and whether the right number of ticks fell in each window. A start value that differs from the background reload value shows whether the first reload takes the background value without disturbing the running count. The interrupt flag is toggled with the enable both set and clear on each channel, which separates the raw flag, the masked flag and the OR onto `irq`.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 12;

    // Word index within a channel window
    typedef enum logic [2:0] {
        WSEL_RELOAD   = 3'd0,
        WSEL_COUNT    = 3'd1,
        WSEL_CTRL     = 3'd2,
        WSEL_CLEAR    = 3'd3,
        WSEL_RAW      = 3'd4,
        WSEL_MASKED   = 3'd5,
        WSEL_BGRELOAD = 3'd6,
        WSEL_NONE     = 3'd7
    } wsel_e;

    // Control word, bit 7 down to bit 0
    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] prediv;
        logic       wide;
        logic       single;
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h04;
            3'd1:    b = 8'h18;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dtimer_prescale.sv
module dtimer_prescale #(
    parameter int unsigned SLOW_LOG2 = 4,
    parameter int unsigned SLOWER_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int unsigned CW = (SLOWER_LOG2 > SLOW_LOG2) ? SLOWER_LOG2 : SLOW_LOG2;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clear ? '0 : cnt_q + 1'b1;
        case (rate)
            2'b01:   tick = &cnt_q[SLOW_LOG2-1:0];
            2'b10:   tick = &cnt_q[SLOWER_LOG2-1:0];
            default: tick = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel
    import dtimer_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SLOW_LOG2   = 4,
    parameter int unsigned SLOWER_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  wsel_e            wsel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rd_val,
    output logic             irq_o
);

    localparam int unsigned HALF = CNT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
        ctrl_t            ctrl;
        logic             raw;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic             tick;
    logic             ctrl_wr;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] full;
    logic [CNT_W-1:0] next_reload;
    logic             hit;

    assign ctrl_wr = we && (wsel == WSEL_CTRL);

    dtimer_prescale #(
        .SLOW_LOG2  (SLOW_LOG2),
        .SLOWER_LOG2(SLOWER_LOG2)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(ctrl_wr),
        .rate (st_q.ctrl.prediv),
        .tick (tick)
    );

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;

        cur  = st_q.ctrl.wide ? st_q.count : {{(CNT_W-HALF){1'b0}}, st_q.count[HALF-1:0]};
        full = st_q.ctrl.wide ? {CNT_W{1'b1}} : {{(CNT_W-HALF){1'b0}}, {HALF{1'b1}}};
        next_reload = (!st_q.ctrl.single && !st_q.ctrl.periodic) ? full : st_q.reload;

        if (st_q.ctrl.run && tick) begin
            if (cur != '0) begin
                st_d.count = cur - 1'b1;
                hit        = (cur == {{(CNT_W-1){1'b0}}, 1'b1});
            end else if (!st_q.ctrl.single) begin
                st_d.count = next_reload;
            end
        end

        if (we) begin
            case (wsel)
                WSEL_RELOAD: begin
                    st_d.reload = wdata;
                    st_d.count  = wdata;
                end
                WSEL_BGRELOAD: st_d.reload = wdata;
                WSEL_CTRL:     st_d.ctrl   = ctrl_t'(wdata[7:0]);
                WSEL_CLEAR:    st_d.raw    = 1'b0;
                default: ;
            endcase
        end

        if (hit) st_d.raw = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.reload <= '0;
            st_q.count  <= '0;
            st_q.ctrl   <= ctrl_t'(CTRL_RESET);
            st_q.raw    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.raw && st_q.ctrl.irq_en;

    always_comb begin
        case (wsel)
            WSEL_RELOAD, WSEL_BGRELOAD: rd_val = st_q.reload;
            WSEL_COUNT:  rd_val = cur;
            WSEL_CTRL:   rd_val = {{(CNT_W-8){1'b0}}, st_q.ctrl};
            WSEL_RAW:    rd_val = {{(CNT_W-1){1'b0}}, st_q.raw};
            WSEL_MASKED: rd_val = {{(CNT_W-1){1'b0}}, irq_o};
            default:     rd_val = '0;
        endcase
    end

endmodule

// File: rtl/dtimer_decode.sv
module dtimer_decode
    import dtimer_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned AW     = ADDR_W,
    parameter int unsigned DW     = BUS_W
) (
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [NUM_CH-1:0][DW-1:0]  ch_rd,
    output logic [NUM_CH-1:0]          ch_we,
    output wsel_e                      wsel,
    output logic [DW-1:0]              rd_next
);

    localparam int unsigned WIN_W  = AW - 5;
    localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [WIN_W-1:0] win;
    logic             aligned;
    logic             in_chan;
    logic             in_ident;
    logic [IDX_W-1:0] idx;

    assign win      = bus_addr[AW-1:5];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign in_chan  = aligned && (32'(win) < NUM_CH);
    assign in_ident = aligned && (&win);
    assign idx      = win[IDX_W-1:0];
    assign wsel     = wsel_e'(bus_addr[4:2]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        assign ch_we[c] = bus_wr && in_chan && (32'(win) == c);
    end

    always_comb begin
        if (in_chan)       rd_next = ch_rd[idx];
        else if (in_ident) rd_next = {{(DW-8){1'b0}}, ident_byte(bus_addr[4:2])};
        else               rd_next = '0;
    end

endmodule

// File: rtl/dtimer_top.sv
module dtimer_top
    import dtimer_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned SLOW_LOG2   = 4,
    parameter int unsigned SLOWER_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_CH-1:0][BUS_W-1:0] ch_rd;
    logic [NUM_CH-1:0]            ch_we;
    logic [NUM_CH-1:0]            ch_irq;
    wsel_e                        wsel;
    logic [BUS_W-1:0]             rd_next;

    dtimer_decode #(
        .NUM_CH(NUM_CH),
        .AW    (ADDR_W),
        .DW    (BUS_W)
    ) u_dec (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .ch_rd   (ch_rd),
        .ch_we   (ch_we),
        .wsel    (wsel),
        .rd_next (rd_next)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dtimer_channel #(
            .CNT_W      (BUS_W),
            .SLOW_LOG2  (SLOW_LOG2),
            .SLOWER_LOG2(SLOWER_LOG2)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (ch_we[c]),
            .wsel  (wsel),
            .wdata (bus_wdata),
            .rd_val(ch_rd[c]),
            .irq_o (ch_irq[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd) st_d.rdata = rd_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = |ch_irq;

endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_rdata
);

    // R2
    id_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'hFE0) |=> (bus_rdata == 32'h0000_0004));

    // R2
    id_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'hFFC) |=> (bus_rdata == 32'h0000_00B1));

    // R1
    testreg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 12'hF00 || bus_addr == 12'hF04)) |=> (bus_rdata == 32'h0));

    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R11
    ctrl_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[11:6] == 6'd0 && bus_addr[4:0] == 5'h08) |=> (bus_rdata[31:8] == 24'h0));

    // R9
    raw_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[11:6] == 6'd0 && bus_addr[4:0] == 5'h10) |=> (bus_rdata[31:1] == 31'h0));

    // R10
    masked_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[11:6] == 6'd0 && bus_addr[4:0] == 5'h14) |=> (bus_rdata[31:1] == 31'h0));

endmodule

bind dtimer_top dtimer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/dtimer_top_tb.sv
module dtimer_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dtimer_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // Count after k edges following a control write, from a stopped channel holding start
    function automatic logic [31:0] model(input logic [31:0] start, input logic [31:0] rel,
                                          input bit single, input bit wide,
                                          input int divlog, input int k);
        logic [31:0] m;
        logic [31:0] v;
        int t;
        m = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        v = start & m;
        t = k >> divlog;
        for (int i = 0; i < t; i++) begin
            if (v != 0)       v = v - 1;
            else if (!single) v = rel & m;
        end
        return v;
    endfunction

    task automatic sweep(input string req, input logic [11:0] base,
                         input logic [31:0] start, input logic [31:0] rel,
                         input bit single, input bit wide, input int divlog,
                         input logic [31:0] ctrl, input int n);
        logic [31:0] d;
        wr(base + 12'h08, ctrl);
        for (int j = 1; j <= n; j++) begin
            rd(base + 12'h04, d);
            check(req, d, model(start, rel, single, wide, divlog, j - 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] ids [8];
        ids = '{32'h04, 32'h18, 32'h14, 32'h00, 32'h0D, 32'hF0, 32'h05, 32'hB1};
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3 reset state
        rdchk("R3 ctrl0", 12'h008, 32'h20);
        rdchk("R3 ctrl1", 12'h028, 32'h20);
        rdchk("R3 count0", 12'h004, 32'h0);
        rdchk("R3 reload1", 12'h020, 32'h0);
        rdchk("R3 raw0", 12'h010, 32'h0);
        rdchk("R3 masked1", 12'h034, 32'h0);
        check("R3 irq", {31'h0, irq}, 32'h0);

        // R2 identification sweep
        for (int i = 0; i < 8; i++)
            rdchk("R2 ident", 12'hFE0 + 12'(i * 4), ids[i]);

        // R1 undecoded reads
        rdchk("R1 f00", 12'hF00, 32'h0);
        rdchk("R1 f04", 12'hF04, 32'h0);
        rdchk("R1 word7 ch0", 12'h01C, 32'h0);
        rdchk("R1 word7 ch1", 12'h03C, 32'h0);
        rdchk("R1 0x40", 12'h040, 32'h0);
        rdchk("R1 0x800", 12'h800, 32'h0);
        rdchk("R1 unaligned", 12'h00A, 32'h0);

        // R11 control readback
        wr(12'h008, 32'hFFFF_FF5B);
        rdchk("R11 ctrl readback", 12'h008, 32'h5B);
        wr(12'h008, 32'h0);

        // R6 periodic, 32-bit, divide by 1
        wr(12'h000, 32'd5);
        sweep("R6 periodic", 12'h000, 5, 5, 0, 1, 0, 32'hE2, 14);
        wr(12'h00C, 32'hDEAD_BEEF);
        rdchk("R9 clear", 12'h010, 32'h0);
        check("R10 irq after clear", {31'h0, irq}, 32'h0);
        wr(12'h008, 32'h0);
        rdchk("R9 raw set on zero", 12'h010, 32'h1);
        rdchk("R10 masked when disabled", 12'h014, 32'h0);
        check("R10 irq masked", {31'h0, irq}, 32'h0);

        // R5 background reload
        wr(12'h000, 32'd1);
        wr(12'h018, 32'd3);
        rdchk("R5 count untouched", 12'h004, 32'd1);
        rdchk("R5 reload via word0", 12'h000, 32'd3);
        rdchk("R5 reload via word6", 12'h018, 32'd3);
        sweep("R5 next reload", 12'h000, 1, 3, 0, 1, 0, 32'hC2, 8);
        wr(12'h008, 32'h0);

        // R6 one-shot
        wr(12'h00C, 32'h0);
        wr(12'h000, 32'd3);
        sweep("R6 one-shot", 12'h000, 3, 3, 1, 1, 0, 32'hA3, 8);
        rdchk("R9 one-shot raw", 12'h010, 32'h1);
        check("R10 irq ch0", {31'h0, irq}, 32'h1);
        wr(12'h000, 32'd2);
        rdchk("R6 one-shot restart", 12'h004, 32'd2);
        rdchk("R6 one-shot restart step", 12'h004, 32'd1);
        wr(12'h008, 32'h0);
        check("R10 irq ch0 masked", {31'h0, irq}, 32'h0);

        // R4 and R7 on channel 1
        wr(12'h020, 32'h0001_2345);
        rdchk("R7 16-bit view", 12'h024, 32'h0000_2345);
        wr(12'h024, 32'h55);
        rdchk("R4 count write ignored", 12'h024, 32'h0000_2345);
        rdchk("R4 reload stored", 12'h020, 32'h0001_2345);

        // R6 free-running 16-bit
        wr(12'h020, 32'd3);
        sweep("R6 R7 free 16", 12'h020, 3, 32'hFFFF, 0, 0, 0, 32'h80, 7);
        wr(12'h028, 32'h20);
        check("R10 irq ch1", {31'h0, irq}, 32'h1);
        rdchk("R10 masked ch1", 12'h034, 32'h1);
        wr(12'h02C, 32'h1);
        check("R9 clear ch1", {31'h0, irq}, 32'h0);

        // R6 free-running 32-bit
        wr(12'h020, 32'd2);
        sweep("R6 free 32", 12'h020, 2, 32'hFFFF_FFFF, 0, 1, 0, 32'h82, 5);
        wr(12'h028, 32'h0);

        // R8 prescaler settings
        wr(12'h020, 32'd100);
        sweep("R8 div16", 12'h020, 100, 100, 0, 1, 4, 32'hC6, 40);
        wr(12'h028, 32'h0);
        wr(12'h020, 32'd100);
        sweep("R8 div256", 12'h020, 100, 100, 0, 1, 8, 32'hCA, 600);
        wr(12'h028, 32'h0);
        wr(12'h020, 32'd4);
        sweep("R8 code 11", 12'h020, 4, 4, 0, 1, 0, 32'hCE, 8);
        wr(12'h028, 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule